// File: doc/BRIEF.md
# Keyed Watchdog Timer with Control Lock

This block is a watchdog that counts clock cycles and produces two alarms: an interrupt request and a system reset request. Each alarm has its own power-of-two threshold, taken from a 4-bit code in the control word. Software keeps the watchdog quiet by writing a two-byte key pair to the feed word, which returns the count to zero. A separate lock word takes one key that freezes the control word against stray writes and another key that releases it.

Software reaches the block through a 32-bit register port with byte addresses. A write is a single-cycle strobe with an address and a data word. Every write is accepted in the cycle it is presented, so there is no back-pressure. A read is combinational: the data returned follows the address with no delay. The counter can be made to run or halt through three control bits and a sleep input. When the count reaches the end of its range it holds there and does not wrap.

Top module: `wdk_watchdog`

## Requirements
- R1: After reset the control word, the enable word, the lock state and both flags are zero, and irq_o and rst_req_o are low.
- R2: Control bits [3:0] hold the interrupt code and bits [7:4] hold the reset code. Code c gives a threshold of 2^(25-c) counted cycles. A flag becomes visible in the same cycle that the count reaches its threshold, so a timer enabled on a control write shows the flag exactly threshold cycles after that write.
- R3: The count advances only when control bit 8 (timer on) and bit 9 (clock on) are both 1. While sleep_i is high it also needs bit 10 (run in sleep). Otherwise the count holds.
- R4: A write of 0xA5 to offset 0x04 followed by a write of 0x5A to offset 0x04 sets the count to zero on the second write. Only the low byte of each write is compared.
- R5: A feed write of any other value after 0xA5 cancels the sequence. A 0x5A written without a 0xA5 before it has no effect. In both cases the count keeps running.
- R6: The flags word at 0x08 shows the timeout flag in bit 0 and the reset flag in bit 2. A flag stays set until a 1 is written to its bit. Writing 0 leaves it set.
- R7: The enable word at 0x0C uses bit 0 for the interrupt and bit 2 for the reset. irq_o is high only when the timeout flag and enable bit 0 are both 1. rst_req_o is high only when the reset flag and enable bit 2 are both 1.
- R8: The lock word at 0x14 reads back 1 in bit 0 while locked. A low byte of 0x24 locks and 0x42 unlocks; any other value leaves the lock state as it is. While locked, writes to the control word at 0x00 are ignored.
- R9: The reserved offset 0x10 and the feed offset 0x04 read as zero. A write to 0x10 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | System sleep indication |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | 5 | Byte address for both read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request (timeout flag AND its enable) |
| rst_req_o | output | 1 | Reset request (reset flag AND its enable) |

## Verification
Each register write takes effect on the clock edge that captures it. The first count step happens on the following edge, so the bench counts waited edges from the enabling control write, or from the final feed key, and compares that number against the threshold. Flags, irq_o and rst_req_o are sampled one edge before the threshold and exactly at it. Read data is combinational, so the bench sets the address at the falling edge and samples a moment later, before the next rising edge. A randomised section draws codes and wait lengths, and compares the flags and outputs against a threshold function that lives in the bench.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_FEED  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_FLAGS = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_ENA   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_RSVD  = 5'h10;
  localparam logic [ADDR_W-1:0] OFF_LOCK  = 5'h14;

  localparam logic [7:0] KEY_LOCK   = 8'h24;
  localparam logic [7:0] KEY_UNLOCK = 8'h42;
  localparam logic [7:0] KEY_FEED_A = 8'hA5;
  localparam logic [7:0] KEY_FEED_B = 8'h5A;

  localparam int BIT_TIMEOUT = 0;
  localparam int BIT_RESET   = 2;

  typedef enum logic {FEED_IDLE, FEED_ARMED} feed_st_e;
endpackage

// File: rtl/wdk_feed_seq.sv
module wdk_feed_seq
  import wdk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] key_i,
  output logic       feed_o
);
  feed_st_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FEED_IDLE;
    end else if (wr_i) begin
      if (key_i == KEY_FEED_A) st_q <= FEED_ARMED;
      else                     st_q <= FEED_IDLE;
    end
  end

  assign feed_o = wr_i && (st_q == FEED_ARMED) && (key_i == KEY_FEED_B);
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int MAX_LOG2 = 25,
  parameter int CNT_W    = MAX_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             feed_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             step_o
);
  localparam logic [CNT_W-1:0] SAT_VAL = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q;

  assign step_o = run_i && (cnt_q != SAT_VAL) && !feed_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (feed_i) cnt_q <= '0;
    else if (step_o) cnt_q <= cnt_q + CNT_W'(1);
  end

  // R4: a completed key pair restarts the count
  a_r4_feed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    feed_i |=> (cnt_q == '0));

  // R3: with no run condition and no feed the count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !feed_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdk_alarm.sv
module wdk_alarm #(
  parameter int MAX_LOG2 = 25,
  parameter int CODE_W   = 4,
  parameter int CNT_W    = MAX_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              step_i,
  input  logic              clr_i,
  input  logic              en_i,
  output logic              flag_o,
  output logic              out_o
);
  localparam int SH_W = $clog2(MAX_LOG2 + 1);

  logic [SH_W-1:0]  sh;
  logic [CNT_W-1:0] thr;
  logic             set;
  logic             flag_q;

  assign sh  = SH_W'(MAX_LOG2) - SH_W'(code_i);
  assign thr = CNT_W'(1) << sh;
  assign set = step_i && (cnt_i == thr - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign out_o  = flag_q && en_i;

  // R6: a flag only falls by a clear write
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  // R2: a flag rises only as the count steps onto the threshold
  a_r2_flag_onset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(cnt_i) == $past(thr) - CNT_W'(1)));
endmodule

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [1:0]             flag_i,
  output logic [1:0][CODE_W-1:0] codes_o,
  output logic                   tmr_en_o,
  output logic                   clk_en_o,
  output logic                   slp_run_o,
  output logic [1:0]             ena_o,
  output logic                   feed_wr_o,
  output logic [7:0]             feed_key_o,
  output logic [1:0]             clr_o,
  output logic [DATA_W-1:0]      rdata_o
);
  localparam int CTL_W    = 2 * CODE_W + 3;
  localparam int POS_TMR  = 2 * CODE_W;
  localparam int POS_CLK  = 2 * CODE_W + 1;
  localparam int POS_SLP  = 2 * CODE_W + 2;

  logic [CTL_W-1:0] ctrl_q;
  logic [1:0]       ena_q;
  logic             locked_q;
  logic             wr_ctrl, wr_ena, wr_lock, wr_flags;
  logic             unused_wdata;

  assign wr_ctrl  = wr_en_i && (addr_i == OFF_CTRL);
  assign wr_ena   = wr_en_i && (addr_i == OFF_ENA);
  assign wr_lock  = wr_en_i && (addr_i == OFF_LOCK);
  assign wr_flags = wr_en_i && (addr_i == OFF_FLAGS);
  assign unused_wdata = ^wdata_i[DATA_W-1:CTL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ena_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (wr_ctrl && !locked_q) ctrl_q <= wdata_i[CTL_W-1:0];
      if (wr_ena) ena_q <= {wdata_i[BIT_RESET], wdata_i[BIT_TIMEOUT]};
      if (wr_lock) begin
        if (wdata_i[7:0] == KEY_LOCK)        locked_q <= 1'b1;
        else if (wdata_i[7:0] == KEY_UNLOCK) locked_q <= 1'b0;
      end
    end
  end

  assign codes_o[0] = ctrl_q[CODE_W-1:0];
  assign codes_o[1] = ctrl_q[2*CODE_W-1:CODE_W];
  assign tmr_en_o   = ctrl_q[POS_TMR];
  assign clk_en_o   = ctrl_q[POS_CLK];
  assign slp_run_o  = ctrl_q[POS_SLP];
  assign ena_o      = ena_q;
  assign feed_wr_o  = wr_en_i && (addr_i == OFF_FEED);
  assign feed_key_o = wdata_i[7:0];
  assign clr_o      = wr_flags ? {wdata_i[BIT_RESET], wdata_i[BIT_TIMEOUT]} : 2'b00;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL:  rdata_o[CTL_W-1:0] = ctrl_q;
      OFF_FLAGS: begin
        rdata_o[BIT_TIMEOUT] = flag_i[0];
        rdata_o[BIT_RESET]   = flag_i[1];
      end
      OFF_ENA: begin
        rdata_o[BIT_TIMEOUT] = ena_q[0];
        rdata_o[BIT_RESET]   = ena_q[1];
      end
      OFF_LOCK:  rdata_o[0] = locked_q;
      default:   rdata_o = '0;
    endcase
  end

  // R8: a locked control word does not take writes
  a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_ctrl) |=> $stable(ctrl_q));
endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog
  import wdk_pkg::*;
#(
  parameter int MAX_LOG2 = 25,
  parameter int CODE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int CNT_W  = MAX_LOG2 + 1;
  localparam int N_CHAN = 2;

  logic [N_CHAN-1:0][CODE_W-1:0] codes;
  logic [N_CHAN-1:0] ena, clr, flags, outs;
  logic tmr_en, clk_en, slp_run, run;
  logic feed_wr, feed;
  logic [7:0] feed_key;
  logic [CNT_W-1:0] cnt;
  logic step;

  wdk_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .flag_i(flags), .codes_o(codes),
    .tmr_en_o(tmr_en), .clk_en_o(clk_en), .slp_run_o(slp_run),
    .ena_o(ena), .feed_wr_o(feed_wr), .feed_key_o(feed_key),
    .clr_o(clr), .rdata_o(rdata_o)
  );

  wdk_feed_seq u_feed (
    .clk(clk), .rst_n(rst_n), .wr_i(feed_wr), .key_i(feed_key), .feed_o(feed)
  );

  assign run = tmr_en && clk_en && (!sleep_i || slp_run);

  wdk_counter #(.MAX_LOG2(MAX_LOG2), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run), .feed_i(feed),
    .cnt_o(cnt), .step_o(step)
  );

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    wdk_alarm #(.MAX_LOG2(MAX_LOG2), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_alarm (
      .clk(clk), .rst_n(rst_n), .code_i(codes[g]), .cnt_i(cnt),
      .step_i(step), .clr_i(clr[g]), .en_i(ena[g]),
      .flag_o(flags[g]), .out_o(outs[g])
    );
  end

  assign irq_o     = outs[0];
  assign rst_req_o = outs[1];
endmodule

// File: tb/wdk_watchdog_test.sv
module wdk_watchdog_test;
  import wdk_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT_CYC  = 190000;

  logic clk = 1'b0;
  logic rst_n, sleep_i, wr_en_i;
  logic [ADDR_W-1:0] addr_i;
  logic [DATA_W-1:0] wdata_i, rdata_o;
  logic irq_o, rst_req_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdk_watchdog uut (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  function automatic int thr(input int code);
    return 1 << (25 - code);
  endfunction

  function automatic logic [31:0] ctl(input int ic, input int rc,
                                      input bit tmr, input bit ck, input bit slp);
    return {21'b0, slp, ck, tmr, 4'(rc), 4'(ic)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic feed();
    wr(OFF_FEED, 32'hA5);
    wr(OFF_FEED, 32'h5A);
  endtask

  task automatic restart(input int ic, input int rc);
    wr(OFF_CTRL, ctl(ic, rc, 0, 0, 0));
    feed();
    wr(OFF_FLAGS, 32'h5);
    wr(OFF_CTRL, ctl(ic, rc, 1, 1, 0));
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; sleep_i = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(OFF_CTRL, v);  check("R1 ctrl", v, 0);
    rd(OFF_FLAGS, v); check("R1 flags", v, 0);
    rd(OFF_ENA, v);   check("R1 enable", v, 0);
    rd(OFF_LOCK, v);  check("R1 lock", v, 0);
    check("R1 outputs", {30'b0, irq_o, rst_req_o}, 0);

    // R2 both thresholds, R7 outputs
    wr(OFF_ENA, 32'h5);
    restart(15, 14);
    waitc(1023);
    rd(OFF_FLAGS, v); check("R2 before 1024", v, 0);
    check("R7 irq low", irq_o, 0);
    waitc(1);
    rd(OFF_FLAGS, v); check("R2 at 1024", v, 1);
    check("R7 irq high", irq_o, 1);
    check("R7 rst low", rst_req_o, 0);
    waitc(1023);
    rd(OFF_FLAGS, v); check("R2 before 2048", v, 1);
    waitc(1);
    rd(OFF_FLAGS, v); check("R2 at 2048", v, 5);
    check("R7 rst high", rst_req_o, 1);

    // R7 gating by enable word
    wr(OFF_ENA, 32'h0);
    check("R7 gated", {30'b0, irq_o, rst_req_o}, 0);
    rd(OFF_FLAGS, v); check("R7 flags kept", v, 5);
    wr(OFF_ENA, 32'h5);

    // R6 sticky flags, write-one-to-clear
    wr(OFF_FLAGS, 32'h0);
    rd(OFF_FLAGS, v); check("R6 zero write", v, 5);
    wr(OFF_FLAGS, 32'h1);
    rd(OFF_FLAGS, v); check("R6 clear bit0", v, 4);
    check("R6 irq off", {30'b0, irq_o, rst_req_o}, 1);
    waitc(50);
    rd(OFF_FLAGS, v); check("R6 stays clear", v, 4);
    wr(OFF_FLAGS, 32'h4);
    rd(OFF_FLAGS, v); check("R6 clear bit2", v, 0);

    // R3 run conditions
    wr(OFF_CTRL, ctl(15, 15, 1, 0, 0));
    feed();
    wr(OFF_FLAGS, 32'h5);
    waitc(1100);
    rd(OFF_FLAGS, v); check("R3 no clock bit", v, 0);
    sleep_i = 1'b1;
    wr(OFF_CTRL, ctl(15, 15, 1, 1, 0));
    waitc(1100);
    rd(OFF_FLAGS, v); check("R3 sleep halts", v, 0);
    wr(OFF_CTRL, ctl(15, 15, 1, 1, 1));
    waitc(1023);
    rd(OFF_FLAGS, v); check("R3 sleep run before", v, 0);
    waitc(1);
    rd(OFF_FLAGS, v); check("R3 sleep run at", v, 5);
    sleep_i = 1'b0;

    // R4 feed mid-count
    restart(15, 15);
    waitc(800);
    feed();
    waitc(1023);
    rd(OFF_FLAGS, v); check("R4 fed before", v, 0);
    waitc(1);
    rd(OFF_FLAGS, v); check("R4 fed at", v, 5);

    // R5 aborted sequence
    restart(15, 15);
    waitc(600);
    wr(OFF_FEED, 32'hA5);
    wr(OFF_FEED, 32'h11);
    wr(OFF_FEED, 32'h5A);
    waitc(420);
    rd(OFF_FLAGS, v); check("R5 abort before", v, 0);
    waitc(1);
    rd(OFF_FLAGS, v); check("R5 abort at", v, 5);
    // R5 lone second key
    restart(15, 15);
    waitc(900);
    wr(OFF_FEED, 32'h5A);
    waitc(122);
    rd(OFF_FLAGS, v); check("R5 lone before", v, 0);
    waitc(1);
    rd(OFF_FLAGS, v); check("R5 lone at", v, 5);

    // R8 lock
    wr(OFF_LOCK, 32'h24);
    rd(OFF_LOCK, v); check("R8 locked", v, 1);
    wr(OFF_CTRL, 32'h0);
    rd(OFF_CTRL, v); check("R8 ctrl frozen", v, 32'h3FF);
    wr(OFF_LOCK, 32'h77);
    rd(OFF_LOCK, v); check("R8 other key", v, 1);
    wr(OFF_LOCK, 32'h42);
    rd(OFF_LOCK, v); check("R8 unlocked", v, 0);
    wr(OFF_CTRL, 32'h0AB);
    rd(OFF_CTRL, v); check("R8 ctrl written", v, 32'h0AB);

    // R9 reserved and feed reads
    wr(OFF_RSVD, 32'hFFFF_FFFF);
    rd(OFF_RSVD, v); check("R9 reserved", v, 0);
    rd(OFF_FEED, v); check("R9 feed read", v, 0);
    rd(OFF_CTRL, v); check("R9 ctrl kept", v, 32'h0AB);
    rd(OFF_ENA, v);  check("R9 enable kept", v, 5);

    // R2 and R7 random codes, enables and waits
    for (int it = 0; it < 12; it++) begin
      int ic, rc, w;
      bit e0, e2, f0, f2;
      ic = 13 + int'($urandom % 3);
      rc = 13 + int'($urandom % 3);
      w  = int'($urandom % 4500);
      e0 = 1'($urandom);
      e2 = 1'($urandom);
      wr(OFF_ENA, {29'b0, e2, 1'b0, e0});
      restart(ic, rc);
      waitc(w);
      f0 = (w >= thr(ic));
      f2 = (w >= thr(rc));
      rd(OFF_FLAGS, v); check("R2 random flags", v, {29'b0, f2, 1'b0, f0});
      check("R7 random irq", irq_o, f0 & e0);
      check("R7 random rst", rst_req_o, f2 & e2);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * LIMIT_CYC);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule